// File: doc/BRIEF.md
# Enable-Counting Interrupt Source Aggregator

This block gathers a set of interrupt sources into one CPU interrupt request line. Each source keeps two saturating counters. The assertion count records how many requesters currently drive the source. The enable count records how many independent enable contributions have arrived. A source becomes pending only when its assertion count is nonzero and its enable count has reached that source's own enable maximum. A shared parent counter tracks how many sources are pending. The CPU request is high whenever that counter is nonzero.

Callers adjust a source by pulsing one-cycle strobes: enable-up, enable-down, assert-up and assert-down, one bit per source for each kind. When strobes for several sources arrive together, they are parked in a request register. A lowest-index-first encoder then applies them one source per clock. While parked requests remain, a busy output is high. Any attempt to push a counter past its ceiling or below zero leaves the counter unchanged and sets a sticky error flag.

Top module: `irq_enable_aggregator`

## Requirements
- R1: While reset is low, and after it is released with no strobes, pending, parent_cnt, cpu_irq, busy and err are all zero.
- R2: Source i is pending exactly when its assertion count is nonzero and its enable count equals its enable maximum. That maximum is the 4-bit field EN_MAX[4*i+3:4*i].
- R3: An enable-up strobe raises the source's enable count by one and an enable-down strobe lowers it by one. Up and down for the same source in the same cycle cancel.
- R4: Assert-up and assert-down strobes step the assertion count by one in the same way, and they also cancel when they arrive together.
- R5: parent_cnt always equals the number of pending sources, and it changes by at most one per clock.
- R6: cpu_irq is high exactly when parent_cnt is nonzero.
- R7: When several sources are strobed in one cycle, they are applied one per clock, lowest index first. busy is high after an edge that leaves requests unapplied, and it falls at the edge that applies the last one.
- R8: A strobe for a source whose earlier request is still waiting merges with that request. Each strobe kind is applied at most once per grant.
- R9: Counters saturate at zero, at the source's enable maximum, and at ASSERT_MAX. An attempt beyond these limits leaves the counter unchanged and sets err, which stays high until reset.
- R10: A strobe for a source when nothing is waiting takes effect at the very next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_inc | input | NSRC | Enable-up strobe per source |
| en_dec | input | NSRC | Enable-down strobe per source |
| as_inc | input | NSRC | Assert-up strobe per source |
| as_dec | input | NSRC | Assert-down strobe per source |
| pending | output | NSRC | Per-source pending flag |
| parent_cnt | output | $clog2(NSRC+1) | Number of pending sources |
| cpu_irq | output | 1 | CPU interrupt request |
| busy | output | 1 | Queued adjustments remain |
| err | output | 1 | Sticky saturation error |

## Verification
Timing drives every check. A strobe for one source into an idle block changes pending, parent_cnt, cpu_irq and err at the first rising edge. When k sources are strobed together, the j-th lowest index lands at edge j and busy drops at edge k. The bench drives strobes at a falling edge and samples at the falling edge after each rising edge. In table runs it lets busy drain before it compares. Where the order of application or the merging of requests matters, it checks edge by edge.

// File: rtl/irq_enable_aggregator.sv
module irq_enable_aggregator #(
  parameter int NSRC = 4,
  parameter logic [4*NSRC-1:0] EN_MAX = 16'h1321,
  parameter int ASSERT_MAX = 3,
  localparam int AW = $clog2(ASSERT_MAX + 1),
  localparam int PW = $clog2(NSRC + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] en_inc,
  input  logic [NSRC-1:0] en_dec,
  input  logic [NSRC-1:0] as_inc,
  input  logic [NSRC-1:0] as_dec,
  output logic [NSRC-1:0] pending,
  output logic [PW-1:0]   parent_cnt,
  output logic            cpu_irq,
  output logic            busy,
  output logic            err
);
  localparam logic [AW-1:0] AMAX = AW'(ASSERT_MAX);

  logic [NSRC-1:0] q_ei, q_ed, q_ai, q_ad;
  logic [NSRC-1:0] w_ei, w_ed, w_ai, w_ad, want, grant;
  logic [NSRC-1:0] pend_nxt, src_err;
  logic [PW-1:0]   parent_nxt;
  logic            rise, fall;

  assign w_ei  = q_ei | en_inc;
  assign w_ed  = q_ed | en_dec;
  assign w_ai  = q_ai | as_inc;
  assign w_ad  = q_ad | as_dec;
  assign want  = w_ei | w_ed | w_ai | w_ad;
  assign grant = want & (~want + NSRC'(1));
  assign busy  = |(q_ei | q_ed | q_ai | q_ad);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_ei <= '0;
      q_ed <= '0;
      q_ai <= '0;
      q_ad <= '0;
    end else begin
      q_ei <= w_ei & ~grant;
      q_ed <= w_ed & ~grant;
      q_ai <= w_ai & ~grant;
      q_ad <= w_ad & ~grant;
    end
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    localparam logic [3:0] EMAX = EN_MAX[4*i +: 4];
    logic [3:0]    ecnt, ecnt_nxt;
    logic [AW-1:0] acnt, acnt_nxt;
    logic up_e, dn_e, up_a, dn_a, bad;

    assign up_e = grant[i] & w_ei[i] & ~w_ed[i];
    assign dn_e = grant[i] & w_ed[i] & ~w_ei[i];
    assign up_a = grant[i] & w_ai[i] & ~w_ad[i];
    assign dn_a = grant[i] & w_ad[i] & ~w_ai[i];
    assign bad  = (up_e && ecnt == EMAX) || (dn_e && ecnt == 4'd0) ||
                  (up_a && acnt == AMAX) || (dn_a && acnt == '0);

    always_comb begin
      ecnt_nxt = ecnt;
      if (up_e && ecnt != EMAX) ecnt_nxt = ecnt + 4'd1;
      else if (dn_e && ecnt != 4'd0) ecnt_nxt = ecnt - 4'd1;
      acnt_nxt = acnt;
      if (up_a && acnt != AMAX) acnt_nxt = acnt + AW'(1);
      else if (dn_a && acnt != '0) acnt_nxt = acnt - AW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ecnt <= '0;
        acnt <= '0;
      end else begin
        ecnt <= ecnt_nxt;
        acnt <= acnt_nxt;
      end
    end

    assign pending[i]  = (acnt != '0) && (ecnt == EMAX);
    assign pend_nxt[i] = (acnt_nxt != '0) && (ecnt_nxt == EMAX);
    assign src_err[i]  = bad;
  end

  assign rise = |(pend_nxt & ~pending);
  assign fall = |(pending & ~pend_nxt);

  always_comb begin
    parent_nxt = parent_cnt;
    if (rise) parent_nxt = parent_cnt + PW'(1);
    else if (fall) parent_nxt = parent_cnt - PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      parent_cnt <= '0;
      cpu_irq    <= 1'b0;
      err        <= 1'b0;
    end else begin
      parent_cnt <= parent_nxt;
      cpu_irq    <= parent_nxt != '0;
      err        <= err | (|src_err);
    end
  end
endmodule

// File: rtl/irq_enable_aggregator_chk.sv
module irq_enable_aggregator_chk #(
  parameter int NSRC = 4,
  parameter int PW = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] en_inc,
  input logic [NSRC-1:0] en_dec,
  input logic [NSRC-1:0] as_inc,
  input logic [NSRC-1:0] as_dec,
  input logic [NSRC-1:0] pending,
  input logic [PW-1:0]   parent_cnt,
  input logic            cpu_irq,
  input logic            busy,
  input logic            err
);
  AST_PARENT_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    int'(parent_cnt) == $countones(pending)); // R5

  AST_PARENT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (parent_cnt == $past(parent_cnt)) ||
    (parent_cnt == $past(parent_cnt) + PW'(1)) ||
    (parent_cnt + PW'(1) == $past(parent_cnt))); // R5

  AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq == (parent_cnt != '0)); // R6

  AST_ONE_PER_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pending ^ $past(pending))); // R7

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !(|{en_inc, en_dec, as_inc, as_dec})) |=> $stable(pending)); // R10
endmodule

bind irq_enable_aggregator irq_enable_aggregator_chk #(.NSRC(NSRC), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .en_inc(en_inc), .en_dec(en_dec),
  .as_inc(as_inc), .as_dec(as_dec), .pending(pending),
  .parent_cnt(parent_cnt), .cpu_irq(cpu_irq), .busy(busy), .err(err)
);

// File: tb/tb_irq_enable_aggregator.sv
`timescale 1ns/1ps
module tb_irq_enable_aggregator;
  localparam int NSRC = 4;
  localparam int PW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NSRC-1:0] en_inc = '0, en_dec = '0, as_inc = '0, as_dec = '0;
  logic [NSRC-1:0] pending;
  logic [PW-1:0]   parent_cnt;
  logic cpu_irq, busy, err;
  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  irq_enable_aggregator #(.NSRC(NSRC), .EN_MAX(16'h1321), .ASSERT_MAX(3)) dut (
    .clk(clk), .rst_n(rst_n), .en_inc(en_inc), .en_dec(en_dec),
    .as_inc(as_inc), .as_dec(as_dec), .pending(pending),
    .parent_cnt(parent_cnt), .cpu_irq(cpu_irq), .busy(busy), .err(err));

  // {en_inc, en_dec, as_inc, as_dec, expected pending, expected parent}
  // Enable maxima: src0=1, src1=2, src2=3, src3=1; assertion ceiling 3.
  localparam logic [23:0] VEC [12] = '{
    24'h001000, 24'h100011, 24'h202011, 24'h200032,
    24'h000121, 24'hC080A2, 24'h020081, 24'h880081,
    24'h000800, 24'h404000, 24'h400041, 24'h00F0D3
  };

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic pulse(logic [3:0] ei, logic [3:0] ed, logic [3:0] ai, logic [3:0] ad);
    @(negedge clk);
    en_inc = ei; en_dec = ed; as_inc = ai; as_dec = ad;
    @(negedge clk);
    en_inc = '0; en_dec = '0; as_inc = '0; as_dec = '0;
  endtask

  task automatic drain();
    for (int n = 0; n < 32 && busy; n++) @(negedge clk);
  endtask

  initial begin
    #(100000 * 5);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails + 1, checks + 1);
    $finish;
  end

  initial begin
    #12;
    chk("R1", "pending in reset", pending, 0);
    chk("R1", "cpu_irq in reset", cpu_irq, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", "pending after reset", pending, 0);
    chk("R1", "parent after reset", parent_cnt, 0);
    chk("R1", "busy after reset", busy, 0);
    chk("R1", "err after reset", err, 0);

    // R2 R3 R4 R5 R6: table of adjustments and resulting states
    for (int v = 0; v < 12; v++) begin
      pulse(VEC[v][23:20], VEC[v][19:16], VEC[v][15:12], VEC[v][11:8]);
      drain();
      chk("R2", $sformatf("vec %0d pending", v), pending, VEC[v][7:4]);
      chk("R5", $sformatf("vec %0d parent", v), parent_cnt, VEC[v][3:0]);
      chk("R6", $sformatf("vec %0d cpu_irq", v), cpu_irq, VEC[v][3:0] != 0);
      chk("R9", $sformatf("vec %0d err", v), err, 0);
    end

    // R7 R10: two sources at once, lowest first, one per edge
    pulse(4'h0, 4'h0, 4'h0, 4'h9);
    chk("R7", "after first edge pending", pending, 4'hC);
    chk("R7", "busy with one queued", busy, 1);
    chk("R10", "parent after first edge", parent_cnt, 2);
    @(negedge clk);
    chk("R7", "after second edge pending", pending, 4'h4);
    chk("R7", "busy drained", busy, 0);
    chk("R6", "cpu_irq with one pending", cpu_irq, 1);

    // R8: repeated strobe to a queued source merges
    @(negedge clk);
    en_dec = 4'h6;
    @(negedge clk);
    en_dec = 4'h4;
    chk("R8", "src1 applied first, pending", pending, 4'h4);
    @(negedge clk);
    en_dec = '0;
    chk("R8", "after merge pending", pending, 4'h0);
    chk("R6", "cpu_irq none pending", cpu_irq, 0);
    chk("R8", "busy after merge", busy, 0);
    pulse(4'h4, 4'h0, 4'h0, 4'h0);
    chk("R8", "one up restores max", pending, 4'h4);

    // R9: enable overflow saturates and sets err
    pulse(4'h4, 4'h0, 4'h0, 4'h0);
    chk("R9", "err on enable overflow", err, 1);
    chk("R9", "pending held at max", pending, 4'h4);
    pulse(4'h0, 4'h4, 0, 0);
    chk("R9", "one down leaves max", pending, 4'h0);
    pulse(4'h0, 4'h0, 4'h0, 4'h8);
    repeat (3) @(negedge clk);
    chk("R9", "err sticky", err, 1);

    // R1: reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1", "err cleared by reset", err, 0);
    chk("R1", "parent cleared by reset", parent_cnt, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R4 R9: assertion count saturates at 3
    pulse(4'h1, 4'h0, 4'h0, 4'h0);
    chk("R2", "enabled but unasserted", pending, 4'h0);
    for (int k = 0; k < 4; k++) pulse(4'h0, 4'h0, 4'h1, 4'h0);
    chk("R9", "err on assert overflow", err, 1);
    chk("R4", "asserted pending", pending, 4'h1);
    pulse(4'h0, 4'h0, 4'h1, 4'h1);
    chk("R4", "up and down cancel", pending, 4'h1);
    pulse(4'h0, 4'h0, 4'h0, 4'h1);
    pulse(4'h0, 4'h0, 4'h0, 4'h1);
    chk("R4", "two downs still pending", pending, 4'h1);
    pulse(4'h0, 4'h0, 4'h0, 4'h1);
    chk("R4", "third down clears", pending, 4'h0);
    chk("R6", "cpu_irq drops", cpu_irq, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule